// File: doc/BRIEF.md
# Three-Dimensional DMA Address Generator

This block sequences the addresses of one DMA channel. A parameter set describes a transfer as a cube of bytes. An array is a run of contiguous bytes. A frame is a count of arrays. A set is a count of frames. The source side and the destination side each step by their own signed array index and their own signed frame index. Either index may be zero, which holds a fixed peripheral address or overwrites one location, or negative, which rewinds. A small parameter memory holds several sets. The active set is loaded from one of its entries.

Each synchronisation event produces transfer requests, one per cycle. Each request carries a source address, a destination address and a byte length. In array-sync mode an event moves a single array. In frame-sync mode an event moves every array of the current frame. When the last array of the last frame is issued, the block pulses either an interrupt or a chain trigger, both tagged with a completion code. It then fetches the linked entry. A static option freezes the set so that every event repeats the same requests.

Top module: `dma3d_agen`

## Requirements
- R1: An entry is eight 32-bit words, selected by word index.
  - Word 0 is the source address and word 1 is the destination address.
  - Word 2 holds the array count in [31:16] and the bytes per array in [15:0].
  - Word 3 holds the frame count in [15:0].
  - Word 4 holds the destination array index in [31:16] and the source array index in [15:0].
  - Word 5 holds the frame indices in the same layout as word 4.
  - Word 6 holds the array-count reload in [31:16] and the link in [15:0].
  - Word 7 holds the options: bit0 frame-sync, bit1 static, bit2 interrupt enable, bit3 chain enable, and bits 9:4 the completion code.
  - A start pulse in idle makes the selected entry the active set two clock edges later.
- R2: Each request is registered one edge after the event or burst cycle that produces it. It carries the array start addresses, and its length equals the bytes-per-array field.
- R3: Within a frame, the next array starts at the previous array start plus the signed 16-bit array index of that side. An index of zero or a negative index is allowed.
- R4: In frame-sync mode, one event yields all remaining arrays of the frame on consecutive cycles. An event that arrives during that burst is dropped, and no extra request follows the burst.
- R5: After the last array of a frame, the next frame starts at a base plus the signed frame index. The base is the frame start in frame-sync mode and the last array start in array-sync mode. The array count is reloaded from the reload field.
- R6: The issue of the last array of the last frame sets one completion outcome, held for one cycle together with that request:
  - a chain pulse if chain enable is set;
  - otherwise an interrupt pulse if interrupt enable is set;
  - otherwise no pulse.
  The code output shows the completion code whenever either pulse is high.
- R7: After completion, a link other than 0xFFFF loads the entry given by its low index bits in the next cycle. An event in that load cycle is dropped.
- R8: After completion with link 0xFFFF, the set is left empty. A set whose bytes-per-array, array count or frame count is zero ignores events.
- R9: With the static bit set, addresses and counts never advance and no link is followed. Every event repeats the same requests, and completion fires on each event if the set sits at its last array.
- R10: After reset, no request or completion pulse is output, busy is low and the set is empty.
- R11: A start pulse and an event in the same idle cycle: the start wins and the event is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write one parameter word |
| cfg_entry | input | IDX_W | Entry written |
| cfg_word | input | 3 | Word index within the entry |
| cfg_wdata | input | 32 | Word value |
| act_start | input | 1 | Load an entry as the active set |
| act_entry | input | IDX_W | Entry to load |
| sync_evt | input | 1 | Synchronisation event |
| req_valid | output | 1 | Transfer request present |
| req_src | output | 32 | Source start address of the array |
| req_dst | output | 32 | Destination start address of the array |
| req_len | output | 16 | Bytes in the array |
| done_irq | output | 1 | Set-complete interrupt pulse |
| done_chain | output | 1 | Set-complete chain trigger pulse |
| done_code | output | 6 | Completion code for either pulse |
| busy | output | 1 | Burst or load in progress |

## Verification
Three things fall on the same clock edge: the last request of a set, the completion pulse, and the decision to fetch a linked entry. Right after that edge comes a load cycle in which the block must stay deaf to events. The bench fires an event exactly in that load cycle. It also fires one in the middle of a frame-sync burst, and it raises an event together with a start pulse. In each case it checks that no stray request appears, that the pulse coincides with the final request, and that the next event's addresses come from the newly linked set.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;

    localparam int ADDR_W    = 32;
    localparam int WORD_W    = 32;
    localparam int CNT_W     = 16;
    localparam int CODE_W    = 6;
    localparam int SET_WORDS = 8;
    localparam int WSEL_W    = $clog2(SET_WORDS);

    localparam logic [CNT_W-1:0] LINK_NONE = 16'hFFFF;

    // word positions inside one parameter entry
    localparam int WI_SRC  = 0;
    localparam int WI_DST  = 1;
    localparam int WI_CNT  = 2;
    localparam int WI_CCNT = 3;
    localparam int WI_BIDX = 4;
    localparam int WI_CIDX = 5;
    localparam int WI_LINK = 6;
    localparam int WI_OPT  = 7;

    // option word bit positions
    localparam int OB_AB     = 0;
    localparam int OB_STATIC = 1;
    localparam int OB_IRQ    = 2;
    localparam int OB_CHAIN  = 3;
    localparam int OB_CODE   = 4;

    typedef logic [SET_WORDS-1:0][WORD_W-1:0] set_words_t;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  acnt;
        logic [CNT_W-1:0]  bcnt;
        logic [CNT_W-1:0]  ccnt;
        logic [CNT_W-1:0]  bidx_src;
        logic [CNT_W-1:0]  bidx_dst;
        logic [CNT_W-1:0]  cidx_src;
        logic [CNT_W-1:0]  cidx_dst;
        logic [CNT_W-1:0]  brld;
        logic [CNT_W-1:0]  link;
        logic              ab;
        logic              stat;
        logic              irq_en;
        logic              chain_en;
        logic [CODE_W-1:0] code;
    } pset_t;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] fsrc;
        logic [ADDR_W-1:0] fdst;
        logic [CNT_W-1:0]  bleft;
        logic [CNT_W-1:0]  cleft;
    } cursor_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_LOAD  = 2'd2
    } gen_st_e;

    function automatic logic [ADDR_W-1:0] add_idx(input logic [ADDR_W-1:0] base,
                                                  input logic [CNT_W-1:0]  idx);
        return base + {{(ADDR_W-CNT_W){idx[CNT_W-1]}}, idx};
    endfunction

    function automatic pset_t decode_set(input set_words_t w);
        pset_t s;
        s.src      = w[WI_SRC];
        s.dst      = w[WI_DST];
        s.acnt     = w[WI_CNT][15:0];
        s.bcnt     = w[WI_CNT][31:16];
        s.ccnt     = w[WI_CCNT][15:0];
        s.bidx_src = w[WI_BIDX][15:0];
        s.bidx_dst = w[WI_BIDX][31:16];
        s.cidx_src = w[WI_CIDX][15:0];
        s.cidx_dst = w[WI_CIDX][31:16];
        s.brld     = w[WI_LINK][31:16];
        s.link     = w[WI_LINK][15:0];
        s.ab       = w[WI_OPT][OB_AB];
        s.stat     = w[WI_OPT][OB_STATIC];
        s.irq_en   = w[WI_OPT][OB_IRQ];
        s.chain_en = w[WI_OPT][OB_CHAIN];
        s.code     = w[WI_OPT][OB_CODE +: CODE_W];
        return s;
    endfunction

    function automatic cursor_t first_cursor(input pset_t s);
        cursor_t c;
        c.src   = s.src;
        c.dst   = s.dst;
        c.fsrc  = s.src;
        c.fdst  = s.dst;
        c.bleft = s.bcnt;
        c.cleft = s.ccnt;
        return c;
    endfunction

endpackage

// File: rtl/dma3d_pset_mem.sv
module dma3d_pset_mem
    import dma3d_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int IDX_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_entry,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_entry,
    output set_words_t       rd_words
);

    set_words_t ent_w [N_ENTRIES];

    generate
        for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
            set_words_t words_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    words_q <= '0;
                end else if (wr_en && (wr_entry == IDX_W'(e))) begin
                    words_q[wr_word] <= wr_data;
                end
            end

            assign ent_w[e] = words_q;
        end
    endgenerate

    assign rd_words = ent_w[rd_entry];

endmodule

// File: rtl/dma3d_step.sv
module dma3d_step
    import dma3d_pkg::*;
(
    input  pset_t   cfg,
    input  cursor_t cur,
    output cursor_t nxt,
    output logic    arr_last,
    output logic    frm_last
);

    logic [ADDR_W-1:0] base_src;
    logic [ADDR_W-1:0] base_dst;

    always_comb begin
        arr_last = (cur.bleft <= 16'd1);
        frm_last = (cur.cleft <= 16'd1);
        // frame base: frame start when the whole frame moves per event,
        // otherwise the start of the array just issued
        base_src = cfg.ab ? cur.fsrc : cur.src;
        base_dst = cfg.ab ? cur.fdst : cur.dst;
        nxt      = cur;
        if (!arr_last) begin
            nxt.src   = add_idx(cur.src, cfg.bidx_src);
            nxt.dst   = add_idx(cur.dst, cfg.bidx_dst);
            nxt.bleft = cur.bleft - 16'd1;
        end else begin
            nxt.src   = add_idx(base_src, cfg.cidx_src);
            nxt.dst   = add_idx(base_dst, cfg.cidx_dst);
            nxt.fsrc  = add_idx(base_src, cfg.cidx_src);
            nxt.fdst  = add_idx(base_dst, cfg.cidx_dst);
            nxt.bleft = cfg.brld;
            nxt.cleft = cur.cleft - 16'd1;
        end
    end

endmodule

// File: rtl/dma3d_agen.sv
module dma3d_agen
    import dma3d_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_entry,
    input  logic [2:0]       cfg_word,
    input  logic [31:0]      cfg_wdata,
    input  logic             act_start,
    input  logic [IDX_W-1:0] act_entry,
    input  logic             sync_evt,
    output logic             req_valid,
    output logic [31:0]      req_src,
    output logic [31:0]      req_dst,
    output logic [15:0]      req_len,
    output logic             done_irq,
    output logic             done_chain,
    output logic [5:0]       done_code,
    output logic             busy
);

    typedef struct packed {
        gen_st_e           st;
        pset_t             set;
        cursor_t           com;
        cursor_t           wrk;
        logic [IDX_W-1:0]  ld_idx;
        logic              rv;
        logic [ADDR_W-1:0] rsrc;
        logic [ADDR_W-1:0] rdst;
        logic [CNT_W-1:0]  rlen;
        logic              irq;
        logic              chn;
        logic [CODE_W-1:0] code;
    } regs_t;

    regs_t      r_d, r_q;
    set_words_t mem_words;
    pset_t      ld_set;
    cursor_t    cur;
    cursor_t    nxt;
    logic       arr_last;
    logic       frm_last;
    logic       set_null;
    logic       unit_end;
    logic       set_end;

    dma3d_pset_mem #(
        .N_ENTRIES (N_ENTRIES),
        .IDX_W     (IDX_W)
    ) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_entry (cfg_entry),
        .wr_word  (cfg_word),
        .wr_data  (cfg_wdata),
        .rd_entry (r_q.ld_idx),
        .rd_words (mem_words)
    );

    assign ld_set = decode_set(mem_words);
    assign cur    = (r_q.st == ST_BURST) ? r_q.wrk : r_q.com;

    dma3d_step u_step (
        .cfg      (r_q.set),
        .cur      (cur),
        .nxt      (nxt),
        .arr_last (arr_last),
        .frm_last (frm_last)
    );

    assign set_null = (r_q.com.cleft == '0) || (r_q.com.bleft == '0) || (r_q.set.acnt == '0);
    assign unit_end = !r_q.set.ab || arr_last;
    assign set_end  = arr_last && frm_last;

    always_comb begin
        r_d     = r_q;
        r_d.rv  = 1'b0;
        r_d.irq = 1'b0;
        r_d.chn = 1'b0;
        unique case (r_q.st)
            ST_LOAD: begin
                r_d.set = ld_set;
                r_d.com = first_cursor(ld_set);
                r_d.st  = ST_IDLE;
            end
            ST_IDLE, ST_BURST: begin
                if ((r_q.st == ST_IDLE) && act_start) begin
                    r_d.ld_idx = act_entry;
                    r_d.st     = ST_LOAD;
                end else if ((r_q.st == ST_BURST) || (sync_evt && !set_null)) begin
                    r_d.rv   = 1'b1;
                    r_d.rsrc = cur.src;
                    r_d.rdst = cur.dst;
                    r_d.rlen = r_q.set.acnt;
                    if (!unit_end) begin
                        r_d.wrk = nxt;
                        r_d.st  = ST_BURST;
                    end else begin
                        r_d.st = ST_IDLE;
                        if (!r_q.set.stat) begin
                            r_d.com = nxt;
                        end
                        if (set_end) begin
                            r_d.chn = r_q.set.chain_en;
                            r_d.irq = r_q.set.irq_en && !r_q.set.chain_en;
                            if (r_q.set.chain_en || r_q.set.irq_en) begin
                                r_d.code = r_q.set.code;
                            end
                            if (!r_q.set.stat && (r_q.set.link != LINK_NONE)) begin
                                r_d.ld_idx = r_q.set.link[IDX_W-1:0];
                                r_d.st     = ST_LOAD;
                            end
                        end
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_valid  = r_q.rv;
    assign req_src    = r_q.rsrc;
    assign req_dst    = r_q.rdst;
    assign req_len    = r_q.rlen;
    assign done_irq   = r_q.irq;
    assign done_chain = r_q.chn;
    assign done_code  = r_q.code;
    assign busy       = (r_q.st != ST_IDLE);

    AST_REQ_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.rv |-> (r_q.rlen != '0)); // R2

    AST_BURST_FLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_BURST) |=> r_q.rv); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.irq && r_q.chn)); // R6

    AST_DONE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.irq || r_q.chn) |-> r_q.rv); // R6

    AST_LOAD_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_LOAD) |=> !r_q.rv); // R7

    AST_NULL_SET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_IDLE) && set_null) |=> !r_q.rv); // R8

    AST_STATIC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st != ST_LOAD) && r_q.set.stat) |=> $stable(r_q.com)); // R9

    AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_IDLE) && act_start) |=> ((r_q.st == ST_LOAD) && !r_q.rv)); // R11

endmodule

// File: tb/sim_dma3d_agen.sv
module sim_dma3d_agen;
    import dma3d_pkg::*;

    localparam int NE = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [IW-1:0] cfg_entry;
    logic [2:0]    cfg_word;
    logic [31:0]   cfg_wdata;
    logic          act_start;
    logic [IW-1:0] act_entry;
    logic          sync_evt;
    logic          req_valid;
    logic [31:0]   req_src;
    logic [31:0]   req_dst;
    logic [15:0]   req_len;
    logic          done_irq;
    logic          done_chain;
    logic [5:0]    done_code;
    logic          busy;

    always #10 clk = ~clk;

    dma3d_agen #(.N_ENTRIES(NE), .IDX_W(IW)) u0 (
        .clk (clk), .rst_n (rst_n),
        .cfg_we (cfg_we), .cfg_entry (cfg_entry), .cfg_word (cfg_word), .cfg_wdata (cfg_wdata),
        .act_start (act_start), .act_entry (act_entry), .sync_evt (sync_evt),
        .req_valid (req_valid), .req_src (req_src), .req_dst (req_dst), .req_len (req_len),
        .done_irq (done_irq), .done_chain (done_chain), .done_code (done_code), .busy (busy)
    );

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] img [NE][8];

    // reference model of the active set
    logic [31:0] m_src, m_dst, m_fsrc, m_fdst;
    logic [15:0] m_bl, m_cl, m_acnt, m_brld, m_link;
    logic [15:0] m_bis, m_bid, m_cis, m_cid;
    logic        m_ab, m_stat, m_irq, m_chn;
    logic [5:0]  m_code;

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_load(input int e);
        m_src  = img[e][0];          m_dst  = img[e][1];
        m_fsrc = img[e][0];          m_fdst = img[e][1];
        m_acnt = img[e][2][15:0];    m_bl   = img[e][2][31:16];
        m_cl   = img[e][3][15:0];
        m_bis  = img[e][4][15:0];    m_bid  = img[e][4][31:16];
        m_cis  = img[e][5][15:0];    m_cid  = img[e][5][31:16];
        m_link = img[e][6][15:0];    m_brld = img[e][6][31:16];
        m_ab   = img[e][7][0];       m_stat = img[e][7][1];
        m_irq  = img[e][7][2];       m_chn  = img[e][7][3];
        m_code = img[e][7][9:4];
    endtask

    task automatic wr_set(input int e, input logic [31:0] src, input logic [31:0] dst,
                          input logic [15:0] acnt, input logic [15:0] bcnt, input logic [15:0] ccnt,
                          input logic [15:0] bis, input logic [15:0] bid,
                          input logic [15:0] cis, input logic [15:0] cid,
                          input logic [15:0] brld, input logic [15:0] link,
                          input logic ab, input logic stat, input logic irq, input logic chn,
                          input logic [5:0] code);
        img[e][0] = src;
        img[e][1] = dst;
        img[e][2] = {bcnt, acnt};
        img[e][3] = {16'h0, ccnt};
        img[e][4] = {bid, bis};
        img[e][5] = {cid, cis};
        img[e][6] = {brld, link};
        img[e][7] = {22'h0, code, chn, irq, stat, ab};
        for (int w = 0; w < 8; w++) begin
            cfg_we    = 1'b1;
            cfg_entry = IW'(e);
            cfg_word  = 3'(w);
            cfg_wdata = img[e][w];
            @(negedge clk);
        end
        cfg_we = 1'b0;
    endtask

    task automatic activate(input int e);
        act_start = 1'b1;
        act_entry = IW'(e);
        @(negedge clk);
        act_start = 1'b0;
        chk("R1 no request while loading", {31'h0, req_valid}, 32'h0);
        @(negedge clk);
        model_load(e);
    endtask

    // one event; poke_mid drops an event into a burst, poke_ld into a load cycle
    task automatic fire(input bit poke_mid, input bit poke_ld);
        logic [31:0] c_src, c_dst, c_fs, c_fd, bs, bd;
        logic [15:0] c_bl, c_cl;
        bit go, la, lf, sd, poked;
        go    = !((m_cl == 0) || (m_bl == 0) || (m_acnt == 0));
        c_src = m_src; c_dst = m_dst; c_fs = m_fsrc; c_fd = m_fdst; c_bl = m_bl; c_cl = m_cl;
        sd    = 1'b0;
        poked = 1'b0;
        sync_evt = 1'b1;
        @(negedge clk);
        sync_evt = 1'b0;
        if (!go) begin
            chk("R8 empty set ignores event", {31'h0, req_valid}, 32'h0);
            chk("R8 no pulse", {30'h0, done_irq, done_chain}, 32'h0);
            return;
        end
        forever begin
            chk("R2 R3 R5 request valid", {31'h0, req_valid}, 32'h1);
            chk("R3 R5 source address", req_src, c_src);
            chk("R3 R5 destination address", req_dst, c_dst);
            chk("R1 R2 length", {16'h0, req_len}, {16'h0, m_acnt});
            la = (c_bl <= 1);
            lf = (c_cl <= 1);
            sd = la && lf;
            chk("R6 chain pulse", {31'h0, done_chain}, {31'h0, sd && m_chn});
            chk("R6 interrupt pulse", {31'h0, done_irq}, {31'h0, sd && m_irq && !m_chn});
            if (sd && (m_irq || m_chn)) chk("R6 code", {26'h0, done_code}, {26'h0, m_code});
            if (!la) begin
                c_src = c_src + sx(m_bis);
                c_dst = c_dst + sx(m_bid);
                c_bl  = c_bl - 1;
            end else begin
                bs    = m_ab ? c_fs : c_src;
                bd    = m_ab ? c_fd : c_dst;
                c_src = bs + sx(m_cis);
                c_dst = bd + sx(m_cid);
                c_fs  = c_src;
                c_fd  = c_dst;
                c_bl  = m_brld;
                c_cl  = c_cl - 1;
            end
            if (!m_ab || la) break;
            if (poke_mid && !poked) begin
                sync_evt = 1'b1;
                poked    = 1'b1;
            end
            @(negedge clk);
            sync_evt = 1'b0;
        end
        if (!m_stat) begin
            m_src = c_src; m_dst = c_dst; m_fsrc = c_fs; m_fdst = c_fd; m_bl = c_bl; m_cl = c_cl;
        end
        if (sd && !m_stat && (m_link != 16'hFFFF)) begin
            if (poke_ld) sync_evt = 1'b1;
            @(negedge clk);
            sync_evt = 1'b0;
            chk("R7 load cycle silent", {31'h0, req_valid}, 32'h0);
            model_load(int'(m_link[IW-1:0]));
        end
        @(negedge clk);
        chk("R4 R7 no stray request", {31'h0, req_valid}, 32'h0);
    endtask

    function automatic logic [15:0] rnd_idx(input int span);
        return 16'($signed($urandom_range(2 * span)) - span);
    endfunction

    initial begin
        #(20ns * 190000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd1357);
        rst_n = 1'b0; cfg_we = 1'b0; cfg_entry = '0; cfg_word = '0; cfg_wdata = '0;
        act_start = 1'b0; act_entry = '0; sync_evt = 1'b0;
        m_acnt = 0; m_bl = 0; m_cl = 0; m_stat = 0; m_ab = 0; m_link = 16'hFFFF;
        m_irq = 0; m_chn = 0; m_code = 0; m_src = 0; m_dst = 0; m_fsrc = 0; m_fdst = 0;
        m_bis = 0; m_bid = 0; m_cis = 0; m_cid = 0; m_brld = 0;
        for (int e = 0; e < NE; e++) for (int w = 0; w < 8; w++) img[e][w] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 request low", {31'h0, req_valid}, 32'h0);
        chk("R10 pulses low", {30'h0, done_irq, done_chain}, 32'h0);
        chk("R10 busy low", {31'h0, busy}, 32'h0);
        fire(1'b0, 1'b0);

        // fixed peripheral source, destination advancing, array-sync, interrupt, no link
        wr_set(0, 32'h01D0_2000, 32'h8C22_0000, 16'd4, 16'd4, 16'd2,
               16'h0000, 16'h0004, 16'h0000, 16'h0004, 16'd4, 16'hFFFF,
               1'b0, 1'b0, 1'b1, 1'b0, 6'd5);
        // halfword overwrite with rewinding source, frame-sync, links to entry 2
        wr_set(1, 32'h0000_4000, 32'h0000_9000, 16'd2, 16'd2, 16'd3,
               16'h0002, 16'h0000, 16'hFFFE, 16'h0002, 16'd2, 16'h0002,
               1'b1, 1'b0, 1'b1, 1'b0, 6'd3);
        // static single array with chain, link ignored
        wr_set(2, 32'h0000_0100, 32'h0000_0200, 16'd4, 16'd1, 16'd1,
               16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'd1, 16'h0000,
               1'b0, 1'b1, 1'b1, 1'b1, 6'd9);
        // empty set (frame count zero)
        wr_set(3, 32'h0000_0300, 32'h0000_0400, 16'd4, 16'd2, 16'd0,
               16'h0004, 16'h0004, 16'h0000, 16'h0000, 16'd2, 16'hFFFF,
               1'b1, 1'b0, 1'b1, 1'b0, 6'd1);

        activate(0);
        for (int i = 0; i < 9; i++) fire(1'b0, 1'b0);   // last one hits the emptied set (R8)

        activate(1);
        fire(1'b1, 1'b0);
        fire(1'b0, 1'b0);
        fire(1'b1, 1'b1);                                // completes, links to static entry
        for (int i = 0; i < 3; i++) fire(1'b0, 1'b0);    // R9 repeats with chain each time

        // R11 start and event in the same idle cycle
        act_start = 1'b1; act_entry = IW'(1); sync_evt = 1'b1;
        @(negedge clk);
        act_start = 1'b0; sync_evt = 1'b0;
        chk("R11 event dropped for start", {31'h0, req_valid}, 32'h0);
        @(negedge clk);
        model_load(1);
        chk("R11 still silent", {31'h0, req_valid}, 32'h0);
        fire(1'b0, 1'b0);

        activate(3);
        fire(1'b0, 1'b0);

        // randomised sets among entries 4..7
        for (int it = 0; it < 40; it++) begin
            for (int e = 4; e < 8; e++) begin
                logic [15:0] lk;
                lk = ($urandom_range(2) == 0) ? 16'hFFFF : 16'(4 + $urandom_range(3));
                wr_set(e, $urandom(), $urandom(),
                       16'($urandom_range(8)), 16'(1 + $urandom_range(3)), 16'(1 + $urandom_range(2)),
                       rnd_idx(8), rnd_idx(8), rnd_idx(16), rnd_idx(16),
                       16'($urandom_range(4)), lk,
                       1'($urandom_range(1)), ($urandom_range(7) == 0),
                       1'($urandom_range(1)), 1'($urandom_range(1)), 6'($urandom()));
            end
            activate(4);
            for (int k = 0; k < 12; k++) fire(1'($urandom_range(1)), 1'($urandom_range(1)));
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule